// File: doc/BRIEF.md
# Video Sync Pin Direction Controller

This block owns the two bidirectional sync and handshake pins of a video output port. It decides from the control settings whether each pin is driven and what it carries. When the port is the timing master, both pins are driven. In the two video-refresh modes, pin 1 carries the line sync and pin 2 carries the frame sync. In the two data-transfer modes, pin 1 carries a start-of-message marker and pin 2 carries an end-of-message marker.

When the port is a timing slave, neither pin is driven. In a video-refresh mode, pin 2 then acts as the external frame time reference. Its level is brought into the clock domain through a multi-flop synchronizer. The edge selected by a polarity bit then produces a single-cycle frame reference pulse for the timing generator.

The timing generator and the pad cells sit outside this block. The pad's output-enable and output value come from the `pin*_oe` and `pin*_out` ports, and the pad's input value arrives on `pin2_in`. Only pin 2 has a polarity control, because pin 1 is never used as an input.

Top module: `vsp_pin_ctl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next values of `pin1_oe`, `pin2_oe`, `pin1_out`, `pin2_out` and `frame_ref_pulse` are all 0. After reset, `cfg_master` is expected to be 0, so the port comes up as a slave with both pins released.
- R2: One clock after any setting of `cfg_master`, `pin1_oe` and `pin2_oe` both equal that setting.
- R3: With `cfg_master`=1 and `cfg_mode` set to 2'b00 or 2'b01 (video-refresh), `pin1_out` follows `line_sync` and `pin2_out` follows `frame_sync` one clock later. The message pulses are ignored.
- R4: With `cfg_master`=1 and `cfg_mode` set to 2'b10 (data streaming) or 2'b11 (message passing), `pin1_out` follows `msg_start` and `pin2_out` follows `msg_end` one clock later. The sync pulses are ignored.
- R5: With `cfg_master`=0, one clock later both drive values are 0 and both output-enables are 0, whatever the sync and message pulses do.
- R6: With `cfg_master`=0, a video-refresh mode and `cfg_pol2`=1, a low-to-high change on `pin2_in` makes `frame_ref_pulse` high for exactly one clock. The pulse is visible after the third rising clock edge that follows the change.
- R7: With `cfg_master`=0, a video-refresh mode and `cfg_pol2`=0, a high-to-low change on `pin2_in` gives the same single pulse with the same latency.
- R8: A change on `pin2_in` in the direction opposite to the one `cfg_pol2` selects produces no pulse.
- R9: No pulse is produced when `cfg_master`=1, or when `cfg_mode` is a data-transfer mode, whatever `pin2_in` does.
- R10: No pulse is produced during the first SYNC_STAGES+1 clocks after reset is released, even if `pin2_in` rests at the active level. Edge detection starts only when every synchronizer stage and the edge-history flop hold sampled pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Operating mode: 00/01 video-refresh, 10 data streaming, 11 message passing |
| cfg_master | input | 1 | 1: drive both pins; 0: release both, pin 2 is an input |
| cfg_pol2 | input | 1 | Active edge of pin 2 input: 1 rising, 0 falling |
| line_sync | input | 1 | Internal line timing pulse |
| frame_sync | input | 1 | Internal frame timing pulse |
| msg_start | input | 1 | Internal start-of-message marker |
| msg_end | input | 1 | Internal end-of-message marker |
| pin2_in | input | 1 | Level seen at pin 2 pad input (asynchronous) |
| pin1_oe | output | 1 | Output-enable for pin 1 |
| pin1_out | output | 1 | Drive value for pin 1 |
| pin2_oe | output | 1 | Output-enable for pin 2 |
| pin2_out | output | 1 | Drive value for pin 2 |
| frame_ref_pulse | output | 1 | One-clock pulse on the selected pin 2 edge in slave video mode |

## Verification
The bench goes after edge polarity. For each setting it drives both directions of change, so a design with the polarity inverted, or one that fires on any change, shows a pulse on the wrong edge or none on the right one. The pulse is sampled over five clocks to catch a level-style output that stays high, or a pulse that arrives a clock early or late.

The bench also holds pin 2 at its active level through reset. A design without the fill guard would mistake the synchronizer leaving its reset value for an edge. A walk through every mode in both master and slave catches swapped pin roles and a driver left enabled in slave mode. Further runs send edges while the port is the master and while it is in a data mode, where a design that ignores the gating would emit a stray reference pulse.

// File: rtl/vsp_pkg.sv
// Package: shared mode encoding and helpers for the sync pin controller.
// Assumes the mode field is two bits wide and that the encodings below are
// the only values used.
package vsp_pkg;

    typedef enum logic [1:0] {
        VSP_VID_A  = 2'b00,
        VSP_VID_B  = 2'b01,
        VSP_STREAM = 2'b10,
        VSP_MSG    = 2'b11
    } vsp_mode_e;

    localparam int VSP_MODE_W = 2;

    // True for either of the video-refresh modes.
    function automatic logic vsp_is_video(input logic [VSP_MODE_W-1:0] m);
        return (m == VSP_VID_A) || (m == VSP_VID_B);
    endfunction

endpackage

// File: rtl/vsp_sync.sv
// Module: multi-stage level synchronizer for the asynchronous pin input.
// Assumes STAGES >= 2; all stages clear to 0 on reset, so downstream logic
// must ignore the output until the chain has been filled with real samples.
module vsp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Stage 0 samples the raw pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
    end

    // Remaining stages shift the sample along.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/vsp_edge_det.sv
// Module: selectable-polarity edge detector with one-clock pulse output.
// Assumes lvl_i is already synchronous. Detection is held off until FILL
// clocks after reset so reset values are never compared against real samples.
module vsp_edge_det #(
    parameter int FILL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic rise_i,
    input  logic en_i,
    output logic pulse_o
);

    localparam int              CNT_W  = $clog2(FILL + 1);
    localparam logic [CNT_W-1:0] FILL_C = CNT_W'(FILL);

    logic [CNT_W-1:0] fill_q;
    logic             prev_q;
    logic             pulse_q;
    logic             hit;

    // Count clocks since reset, saturating once the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n)               fill_q <= '0;
        else if (fill_q != FILL_C) fill_q <= fill_q + 1'b1;
    end

    // Keep the previous synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Select the active transition by polarity.
    always_comb begin
        if (rise_i) hit = lvl_i & ~prev_q;
        else        hit = ~lvl_i & prev_q;
    end

    // Register the qualified pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= hit & en_i & (fill_q == FILL_C);
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/vsp_pin_mux.sv
// Module: selects the role of each pin and registers its enable and value.
// Assumes the sync and message inputs are synchronous one-clock pulses or
// levels; outputs lag the inputs by one clock.
module vsp_pin_mux
    import vsp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VSP_MODE_W-1:0] mode_i,
    input  logic                  master_i,
    input  logic                  line_i,
    input  logic                  frame_i,
    input  logic                  start_i,
    input  logic                  end_i,
    output logic                  oe1_o,
    output logic                  oe2_o,
    output logic                  out1_o,
    output logic                  out2_o
);

    logic sel1, sel2;

    // Pick the source for each pin from the mode; released pins drive 0.
    always_comb begin
        if (!master_i) begin
            sel1 = 1'b0;
            sel2 = 1'b0;
        end else if (vsp_is_video(mode_i)) begin
            sel1 = line_i;
            sel2 = frame_i;
        end else begin
            sel1 = start_i;
            sel2 = end_i;
        end
    end

    // Register enables and values toward the pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe1_o  <= 1'b0;
            oe2_o  <= 1'b0;
            out1_o <= 1'b0;
            out2_o <= 1'b0;
        end else begin
            oe1_o  <= master_i;
            oe2_o  <= master_i;
            out1_o <= sel1;
            out2_o <= sel2;
        end
    end

endmodule

// File: rtl/vsp_pin_ctl.sv
// Module: top of the video sync pin direction controller.
// Drives both pins in master mode; in slave video mode turns pin 2 into a
// frame reference input with selectable edge. Assumes pads are external.
module vsp_pin_ctl
    import vsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VSP_MODE_W-1:0] cfg_mode,
    input  logic                  cfg_master,
    input  logic                  cfg_pol2,
    input  logic                  line_sync,
    input  logic                  frame_sync,
    input  logic                  msg_start,
    input  logic                  msg_end,
    input  logic                  pin2_in,
    output logic                  pin1_oe,
    output logic                  pin1_out,
    output logic                  pin2_oe,
    output logic                  pin2_out,
    output logic                  frame_ref_pulse
);

    localparam int FILL = SYNC_STAGES + 1;

    logic pin2_sync;
    logic ref_en;

    // Reference detection only while slave in a video-refresh mode.
    assign ref_en = !cfg_master && vsp_is_video(cfg_mode);

    vsp_pin_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (cfg_mode),
        .master_i (cfg_master),
        .line_i   (line_sync),
        .frame_i  (frame_sync),
        .start_i  (msg_start),
        .end_i    (msg_end),
        .oe1_o    (pin1_oe),
        .oe2_o    (pin2_oe),
        .out1_o   (pin1_out),
        .out2_o   (pin2_out)
    );

    vsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin2_in),
        .q_o   (pin2_sync)
    );

    vsp_edge_det #(.FILL(FILL)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (pin2_sync),
        .rise_i  (cfg_pol2),
        .en_i    (ref_en),
        .pulse_o (frame_ref_pulse)
    );

endmodule

// File: rtl/vsp_chk.sv
// Checker: temporal properties of the sync pin controller, bound to the top.
// Assumes the synchronous active-low reset of the design it watches.
module vsp_chk
    import vsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [VSP_MODE_W-1:0] cfg_mode,
    input logic                  cfg_master,
    input logic                  line_sync,
    input logic                  frame_sync,
    input logic                  msg_start,
    input logic                  msg_end,
    input logic                  pin1_oe,
    input logic                  pin1_out,
    input logic                  pin2_oe,
    input logic                  pin2_out,
    input logic                  frame_ref_pulse
);

    localparam int FILL  = SYNC_STAGES + 1;
    localparam int CW    = $clog2(FILL + 2);
    localparam logic [CW-1:0] LIM = CW'(FILL + 1);
    localparam logic [CW-1:0] QUIET = CW'(FILL);

    logic [CW-1:0] since_q;

    // Clocks since reset release, saturating past the fill window.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_q <= '0;
        else if (since_q != LIM) since_q <= since_q + 1'b1;
    end

    AST_OE_FOLLOWS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin1_oe == $past(cfg_master)) && (pin2_oe == $past(cfg_master))); // R2

    AST_VIDEO_ROLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && vsp_is_video(cfg_mode)) |=>
            (pin1_out == $past(line_sync)) && (pin2_out == $past(frame_sync))); // R3

    AST_DATA_ROLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !vsp_is_video(cfg_mode)) |=>
            (pin1_out == $past(msg_start)) && (pin2_out == $past(msg_end))); // R4

    AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |=> !pin1_oe && !pin2_oe && !pin1_out && !pin2_out); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ref_pulse |=> !frame_ref_pulse); // R6

    AST_NO_PULSE_AS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ref_pulse |-> !pin2_oe); // R9

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q <= QUIET) |-> !frame_ref_pulse); // R10

endmodule

bind vsp_pin_ctl vsp_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_mode        (cfg_mode),
    .cfg_master      (cfg_master),
    .line_sync       (line_sync),
    .frame_sync      (frame_sync),
    .msg_start       (msg_start),
    .msg_end         (msg_end),
    .pin1_oe         (pin1_oe),
    .pin1_out        (pin1_out),
    .pin2_oe         (pin2_oe),
    .pin2_out        (pin2_out),
    .frame_ref_pulse (frame_ref_pulse)
);

// File: tb/sim_vsp_pin_ctl.sv
`timescale 1ns/1ps
// Bench: vector table for pin roles, then directed edge and reset tests.
module sim_vsp_pin_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       cfg_master, cfg_pol2;
    logic       line_sync, frame_sync, msg_start, msg_end, pin2_in;
    logic       pin1_oe, pin1_out, pin2_oe, pin2_out, frame_ref_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vsp_pin_ctl #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_master(cfg_master),
        .cfg_pol2(cfg_pol2), .line_sync(line_sync), .frame_sync(frame_sync),
        .msg_start(msg_start), .msg_end(msg_end), .pin2_in(pin2_in),
        .pin1_oe(pin1_oe), .pin1_out(pin1_out), .pin2_oe(pin2_oe),
        .pin2_out(pin2_out), .frame_ref_pulse(frame_ref_pulse)
    );

    // Vector: mode[11:10] master[9] line[8] frame[7] start[6] end[5] spare[4]
    //         exp oe1[3] oe2[2] out1[1] out2[0]
    localparam logic [11:0] VEC [10] = '{
        12'b00_1_1000_0_1110,
        12'b00_1_0111_0_1101,
        12'b01_1_1100_0_1111,
        12'b10_1_1110_0_1110,
        12'b10_1_0001_0_1101,
        12'b11_1_1100_0_1100,
        12'b11_1_0011_0_1111,
        12'b00_0_1111_0_0000,
        12'b11_0_1111_0_0000,
        12'b01_1_0000_0_1100
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Change pin 2 level and record the pulse over the next five clocks.
    task automatic edge_run(input logic lvl, input logic [4:0] exp, input string tag);
        logic [4:0] seen;
        seen = '0;
        @(negedge clk);
        pin2_in = lvl;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            seen[i] = frame_ref_pulse;
        end
        chk(tag, 32'(seen), 32'(exp));
        settle(3);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'b00; cfg_master = 1'b0; cfg_pol2 = 1'b1;
        line_sync = 1'b0; frame_sync = 1'b0; msg_start = 1'b0; msg_end = 1'b0;
        pin2_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 oe", 32'({pin1_oe, pin2_oe}), 32'd0);
        chk("R1 out", 32'({pin1_out, pin2_out}), 32'd0);
        chk("R1 pulse", 32'(frame_ref_pulse), 32'd0);

        // R10: pin rests at active level across reset release
        begin
            logic any;
            any = 1'b0;
            rst_n = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                any = any | frame_ref_pulse;
            end
            chk("R10 no pulse after reset", 32'(any), 32'd0);
        end

        // Vector walk: R2 for enables, R3/R4/R5 for drive values
        for (int i = 0; i < 10; i++) begin
            cfg_mode   = VEC[i][11:10];
            cfg_master = VEC[i][9];
            line_sync  = VEC[i][8];
            frame_sync = VEC[i][7];
            msg_start  = VEC[i][6];
            msg_end    = VEC[i][5];
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2 vec%0d", i), 32'({pin1_oe, pin2_oe}), 32'(VEC[i][3:2]));
            chk($sformatf("%s vec%0d", !VEC[i][9] ? "R5" : (VEC[i][11] ? "R4" : "R3"), i),
                32'({pin1_out, pin2_out}), 32'(VEC[i][1:0]));
        end
        line_sync = 1'b0; frame_sync = 1'b0; msg_start = 1'b0; msg_end = 1'b0;

        // Slave video, rising edge active
        cfg_mode = 2'b00; cfg_master = 1'b0; cfg_pol2 = 1'b1;
        settle(6);
        edge_run(1'b0, 5'b00000, "R8 fall ignored pol2=1");
        edge_run(1'b1, 5'b00100, "R6 rise pulse");

        // Slave video, falling edge active
        cfg_pol2 = 1'b0; cfg_mode = 2'b01;
        settle(6);
        edge_run(1'b0, 5'b00100, "R7 fall pulse");
        edge_run(1'b1, 5'b00000, "R8 rise ignored pol2=0");

        // Master in video mode: no reference pulse
        cfg_pol2 = 1'b1; cfg_mode = 2'b00; cfg_master = 1'b1;
        settle(6);
        edge_run(1'b0, 5'b00000, "R9 master fall");
        edge_run(1'b1, 5'b00000, "R9 master rise");

        // Slave in a data mode: no reference pulse
        cfg_master = 1'b0; cfg_mode = 2'b11;
        settle(6);
        edge_run(1'b0, 5'b00000, "R9 data fall");
        edge_run(1'b1, 5'b00000, "R9 data rise");

        // R1: reset forces driven outputs back to released
        cfg_mode = 2'b00; cfg_master = 1'b1; line_sync = 1'b1; frame_sync = 1'b1;
        settle(2);
        chk("R3 driven before reset", 32'({pin1_oe, pin2_oe, pin1_out, pin2_out}), 32'hF);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset clears drive", 32'({pin1_oe, pin2_oe, pin1_out, pin2_out}), 32'h0);
        rst_n = 1'b1;
        settle(2);

        finish_run();
    end

endmodule